// File: doc/BRIEF.md
# Speculative Load Ordering Checker

This block keeps every in-flight load in program order so that loads are free to read memory before older stores have produced their addresses. A load takes a slot when it is dispatched and gives it back when it retires from the head. When the load actually performs, the pipeline writes its address into the slot and the slot is marked as performed. Retirement is strictly in order from the head. Dispatch stalls while the queue reports that it is full.

A store that has just resolved its address presents that address together with its position in the queue. The position is the value of the queue's tail pointer, wrap bit included, sampled when the store was dispatched. Every slot that is younger than the store, in use and already performed is compared with the store address in the same cycle. Any match means the load read stale data. The block then reports a squash one cycle later that names the oldest such load. In the same clock edge it cuts the queue back so that this load and everything after it are discarded, and refetch brings them back in again.

Top module: `lqv_load_queue`

## Requirements
- R1: After reset the queue is empty: count_o is 0, tail_pos_o is 0, alloc_ready_o is 1 and flush_valid_o is 0.
- R2: An allocation takes the slot tail_pos_o[PW-1:0] and increments tail_pos_o and count_o by one. With DEPTH loads in flight, alloc_ready_o is 0 and an allocation request changes neither count_o nor tail_pos_o.
- R3: A retire request frees the oldest slot and lowers count_o by one. A retire request on an empty queue has no effect.
- R4: A store search that finds a performed, in-use load younger than the store with an equal address sets flush_valid_o in the next cycle, and flush_idx_o then holds that load's slot index.
- R5: A load that has been allocated but has not yet performed never matches, whatever the store address is.
- R6: A load older than the store never matches. A load is older when it was allocated before tail reached the store's st_pos_i.
- R7: A performed younger load whose address differs from the store address does not match.
- R8: When several younger performed loads match, flush_idx_o names the oldest of them in program order.
- R9: When a squash is reported, the queue tail has moved back to the squashed slot. tail_pos_o[PW-1:0] equals flush_idx_o, count_o equals the number of loads older than it, and the next allocation reuses that slot.
- R10: In the cycle a violation is detected, a simultaneous allocation request and a simultaneous retire request are both ignored.
- R11: Age order follows the ring from the head across index wraparound, so an older load can sit at a higher slot index than a younger one.
- R12: flush_valid_o is high only in the cycle after a store search that found a violation. It is a one-cycle pulse for each such search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid_i | input | 1 | Dispatch a load into the slot at the tail |
| alloc_ready_o | output | 1 | Queue can accept a load (not full) |
| tail_pos_o | output | PW+1 | Tail pointer with wrap bit; low bits are the next slot index |
| count_o | output | PW+1 | Number of loads in flight |
| exec_valid_i | input | 1 | A load has performed |
| exec_idx_i | input | PW | Slot of the load that performed |
| exec_addr_i | input | ADDR_W | Address the load read |
| retire_valid_i | input | 1 | Retire the oldest load |
| st_valid_i | input | 1 | A store has resolved its address; search the queue |
| st_pos_i | input | PW+1 | Tail pointer value recorded at the store's dispatch |
| st_addr_i | input | ADDR_W | Resolved store address |
| flush_valid_o | output | 1 | Ordering violation: squash from flush_idx_o onward |
| flush_idx_o | output | PW | Slot of the oldest violating load |

## Verification
The search is tried against queues that hold a single performed younger load with the same address, and against loads that are not yet performed, loads older than the store, and performed loads with a different address. Each of these separates one term of the match condition from the others. A queue with several matching loads shows whether the oldest one is chosen rather than the lowest index. The same case is repeated after the pointers have wrapped, where the two orders disagree. A violation that arrives together with dispatch and retire requests shows that the tail cut takes priority over both.

// File: rtl/lqv_pkg.sv
package lqv_pkg;
    localparam int unsigned LQV_DEPTH_DEF  = 8;
    localparam int unsigned LQV_ADDR_W_DEF = 16;
endpackage

// File: rtl/lqv_match_vec.sv
// Per-slot comparison of a resolving store against every queued load.
module lqv_match_vec #(
    parameter int unsigned DEPTH  = lqv_pkg::LQV_DEPTH_DEF,
    parameter int unsigned ADDR_W = lqv_pkg::LQV_ADDR_W_DEF,
    parameter int unsigned PW     = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0][ADDR_W-1:0] entry_addr_i,
    input  logic [DEPTH-1:0]             entry_exec_i,
    input  logic [PW:0]                  head_i,
    input  logic [PW:0]                  count_i,
    input  logic [PW:0]                  st_pos_i,
    input  logic [ADDR_W-1:0]            st_addr_i,
    output logic [DEPTH-1:0]             hit_o,
    output logic [DEPTH-1:0]             in_use_o
);
    logic [PW:0] st_raw;
    logic [PW:0] st_off;

    // Distance of the store from the head; a store older than every queued
    // load sees the whole queue as younger.
    always_comb begin
        st_raw = st_pos_i - head_i;
        st_off = (st_raw > count_i) ? '0 : st_raw;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [PW-1:0] off;
        assign off         = PW'(g) - head_i[PW-1:0];
        assign in_use_o[g] = ({1'b0, off} < count_i);
        assign hit_o[g]    = in_use_o[g] && entry_exec_i[g] &&
                             ({1'b0, off} >= st_off) &&
                             (entry_addr_i[g] == st_addr_i);
    end
endmodule

// File: rtl/lqv_oldest_pick.sv
// Picks the hit closest to the head in ring order.
module lqv_oldest_pick #(
    parameter int unsigned DEPTH = lqv_pkg::LQV_DEPTH_DEF,
    parameter int unsigned PW    = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] hit_i,
    input  logic [PW-1:0]    head_idx_i,
    output logic             found_o,
    output logic [PW-1:0]    off_o,
    output logic [PW-1:0]    idx_o
);
    logic [PW-1:0] slot;

    always_comb begin
        found_o = 1'b0;
        off_o   = '0;
        slot    = '0;
        // Descending scan: the smallest distance is written last and wins.
        for (int k = DEPTH - 1; k >= 0; k--) begin
            slot = head_idx_i + PW'(k);
            if (hit_i[slot]) begin
                found_o = 1'b1;
                off_o   = PW'(k);
            end
        end
        idx_o = head_idx_i + off_o;
    end
endmodule

// File: rtl/lqv_load_queue.sv
module lqv_load_queue #(
    parameter int unsigned DEPTH  = lqv_pkg::LQV_DEPTH_DEF,
    parameter int unsigned ADDR_W = lqv_pkg::LQV_ADDR_W_DEF,
    localparam int unsigned PW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid_i,
    output logic              alloc_ready_o,
    output logic [PW:0]       tail_pos_o,
    output logic [PW:0]       count_o,
    input  logic              exec_valid_i,
    input  logic [PW-1:0]     exec_idx_i,
    input  logic [ADDR_W-1:0] exec_addr_i,
    input  logic              retire_valid_i,
    input  logic              st_valid_i,
    input  logic [PW:0]       st_pos_i,
    input  logic [ADDR_W-1:0] st_addr_i,
    output logic              flush_valid_o,
    output logic [PW-1:0]     flush_idx_o
);
    typedef struct packed {
        logic [DEPTH-1:0][ADDR_W-1:0] addr;
        logic [DEPTH-1:0]             exec;
        logic [PW:0]                  head;
        logic [PW:0]                  tail;
        logic                         flush_v;
        logic [PW-1:0]                flush_idx;
    } state_t;

    state_t s_q, s_d;

    logic [PW:0]      count;
    logic             full;
    logic [DEPTH-1:0] hit;
    logic [DEPTH-1:0] in_use;
    logic             found;
    logic             viol;
    logic [PW-1:0]    pick_off;
    logic [PW-1:0]    pick_idx;

    assign count = s_q.tail - s_q.head;
    assign full  = (count == (PW+1)'(DEPTH));

    lqv_match_vec #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .PW(PW)) match_i (
        .entry_addr_i (s_q.addr),
        .entry_exec_i (s_q.exec),
        .head_i       (s_q.head),
        .count_i      (count),
        .st_pos_i     (st_pos_i),
        .st_addr_i    (st_addr_i),
        .hit_o        (hit),
        .in_use_o     (in_use)
    );

    lqv_oldest_pick #(.DEPTH(DEPTH), .PW(PW)) pick_i (
        .hit_i      (hit),
        .head_idx_i (s_q.head[PW-1:0]),
        .found_o    (found),
        .off_o      (pick_off),
        .idx_o      (pick_idx)
    );

    assign viol = st_valid_i && found;

    always_comb begin
        s_d         = s_q;
        s_d.flush_v = viol;
        if (viol) begin
            s_d.flush_idx = pick_idx;
        end

        if (exec_valid_i && in_use[exec_idx_i]) begin
            s_d.exec[exec_idx_i] = 1'b1;
            s_d.addr[exec_idx_i] = exec_addr_i;
        end

        if (viol) begin
            // Cut the queue back to the oldest violating load.
            s_d.tail = s_q.head + {1'b0, pick_off};
        end else begin
            if (alloc_valid_i && !full) begin
                s_d.exec[s_q.tail[PW-1:0]] = 1'b0;
                s_d.addr[s_q.tail[PW-1:0]] = '0;
                s_d.tail                   = s_q.tail + 1'b1;
            end
            if (retire_valid_i && (count != '0)) begin
                s_d.head = s_q.head + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign alloc_ready_o = !full;
    assign tail_pos_o    = s_q.tail;
    assign count_o       = count;
    assign flush_valid_o = s_q.flush_v;
    assign flush_idx_o   = s_q.flush_idx;
endmodule

// File: rtl/lqv_load_queue_chk.sv
module lqv_load_queue_chk #(
    parameter int unsigned DEPTH = lqv_pkg::LQV_DEPTH_DEF,
    localparam int unsigned PW   = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          st_valid_i,
    input logic          alloc_ready_o,
    input logic [PW:0]   tail_pos_o,
    input logic [PW:0]   count_o,
    input logic          flush_valid_o,
    input logic [PW-1:0] flush_idx_o
);
    // R2: occupancy bounded by the depth
    p_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= (PW+1)'(DEPTH));

    // R2: a full queue cannot grow in the next cycle
    p_full_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc_ready_o |=> (count_o <= $past(count_o)));

    // R3: without a search, occupancy moves by at most one per cycle
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !st_valid_i |=> ((int'(count_o) <= int'($past(count_o)) + 1) &&
                         (int'(count_o) + 1 >= int'($past(count_o)))));

    // R12: a squash only follows a store search
    p_flush_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid_o |-> $past(st_valid_i));

    // R9: tail sits on the squashed slot
    p_flush_tail_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid_o |-> (tail_pos_o[PW-1:0] == flush_idx_o));

    // R4: the squashed load was in flight, so the queue shrank
    p_flush_shrink_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid_o |-> (count_o < $past(count_o)));
endmodule

bind lqv_load_queue lqv_load_queue_chk #(.DEPTH(DEPTH)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .st_valid_i    (st_valid_i),
    .alloc_ready_o (alloc_ready_o),
    .tail_pos_o    (tail_pos_o),
    .count_o       (count_o),
    .flush_valid_o (flush_valid_o),
    .flush_idx_o   (flush_idx_o)
);

// File: tb/lqv_load_queue_tb_top.sv
module lqv_load_queue_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int ADDR_W     = 16;
    localparam int PW         = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              alloc_valid_i = 1'b0;
    logic              alloc_ready_o;
    logic [PW:0]       tail_pos_o;
    logic [PW:0]       count_o;
    logic              exec_valid_i = 1'b0;
    logic [PW-1:0]     exec_idx_i = '0;
    logic [ADDR_W-1:0] exec_addr_i = '0;
    logic              retire_valid_i = 1'b0;
    logic              st_valid_i = 1'b0;
    logic [PW:0]       st_pos_i = '0;
    logic [ADDR_W-1:0] st_addr_i = '0;
    logic              flush_valid_o;
    logic [PW-1:0]     flush_idx_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lqv_load_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .alloc_valid_i  (alloc_valid_i),
        .alloc_ready_o  (alloc_ready_o),
        .tail_pos_o     (tail_pos_o),
        .count_o        (count_o),
        .exec_valid_i   (exec_valid_i),
        .exec_idx_i     (exec_idx_i),
        .exec_addr_i    (exec_addr_i),
        .retire_valid_i (retire_valid_i),
        .st_valid_i     (st_valid_i),
        .st_pos_i       (st_pos_i),
        .st_addr_i      (st_addr_i),
        .flush_valid_o  (flush_valid_o),
        .flush_idx_o    (flush_idx_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic reset_dut();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic alloc_n(input int n);
        for (int i = 0; i < n; i++) begin
            alloc_valid_i = 1'b1;
            @(negedge clk);
        end
        alloc_valid_i = 1'b0;
    endtask

    task automatic retire_n(input int n);
        for (int i = 0; i < n; i++) begin
            retire_valid_i = 1'b1;
            @(negedge clk);
        end
        retire_valid_i = 1'b0;
    endtask

    task automatic exec_ld(input int idx, input int addr);
        exec_valid_i = 1'b1;
        exec_idx_i   = PW'(idx);
        exec_addr_i  = ADDR_W'(addr);
        @(negedge clk);
        exec_valid_i = 1'b0;
    endtask

    task automatic store(input int pos, input int addr);
        st_valid_i = 1'b1;
        st_pos_i   = (PW+1)'(pos);
        st_addr_i  = ADDR_W'(addr);
        @(negedge clk);
        st_valid_i = 1'b0;
    endtask

    task automatic t_reset();
        reset_dut();
        check("R1 count", int'(count_o), 0);
        check("R1 tail", int'(tail_pos_o), 0);
        check("R1 ready", int'(alloc_ready_o), 1);
        check("R1 flush", int'(flush_valid_o), 0);
    endtask

    task automatic t_fill();
        reset_dut();
        for (int i = 0; i < DEPTH; i++) begin
            alloc_n(1);
            check("R2 tail step", int'(tail_pos_o), i + 1);
        end
        check("R2 count full", int'(count_o), DEPTH);
        check("R2 ready low", int'(alloc_ready_o), 0);
        alloc_n(1);
        check("R2 alloc when full count", int'(count_o), DEPTH);
        check("R2 alloc when full tail", int'(tail_pos_o), DEPTH);
    endtask

    task automatic t_retire();
        retire_n(3);
        check("R3 retire count", int'(count_o), DEPTH - 3);
        check("R3 ready again", int'(alloc_ready_o), 1);
        reset_dut();
        retire_n(1);
        check("R3 empty retire count", int'(count_o), 0);
        alloc_n(1);
        check("R3 empty retire no head move", int'(count_o), 1);
    endtask

    task automatic t_basic();
        reset_dut();
        alloc_n(4);
        exec_ld(2, 'h40);
        store(1, 'h40);
        check("R4 flush valid", int'(flush_valid_o), 1);
        check("R4 flush idx", int'(flush_idx_o), 2);
        check("R9 count after flush", int'(count_o), 2);
        check("R9 tail after flush", int'(tail_pos_o), 2);
        @(negedge clk);
        check("R12 single pulse", int'(flush_valid_o), 0);
        alloc_n(1);
        check("R9 slot reused", int'(tail_pos_o), 3);
    endtask

    task automatic t_no_match();
        reset_dut();
        alloc_n(4);
        store(1, 0);
        check("R5 pending loads ignored", int'(flush_valid_o), 0);
        check("R5 count kept", int'(count_o), 4);
        exec_ld(0, 'h30);
        store(1, 'h30);
        check("R6 older load ignored", int'(flush_valid_o), 0);
        exec_ld(1, 'h55);
        store(1, 'h66);
        check("R7 other address ignored", int'(flush_valid_o), 0);
        check("R7 count kept", int'(count_o), 4);
    endtask

    task automatic t_oldest();
        reset_dut();
        alloc_n(6);
        exec_ld(5, 'h99);
        exec_ld(4, 'h99);
        exec_ld(2, 'h99);
        store(1, 'h99);
        check("R8 oldest idx", int'(flush_idx_o), 2);
        check("R8 count", int'(count_o), 2);
    endtask

    task automatic t_wrap();
        reset_dut();
        alloc_n(6);
        retire_n(6);
        alloc_n(1);
        check("R11 store position", int'(tail_pos_o), 7);
        alloc_n(5);
        check("R11 wrapped tail", int'(tail_pos_o), 12);
        exec_ld(1, 'hAB);
        exec_ld(7, 'hAB);
        store(7, 'hAB);
        check("R11 flush valid", int'(flush_valid_o), 1);
        check("R11 oldest across wrap", int'(flush_idx_o), 7);
        check("R11 count", int'(count_o), 1);
        check("R11 tail", int'(tail_pos_o), 7);
    endtask

    task automatic t_collide();
        reset_dut();
        alloc_n(4);
        exec_ld(2, 'h5);
        alloc_valid_i  = 1'b1;
        retire_valid_i = 1'b1;
        store(0, 'h5);
        alloc_valid_i  = 1'b0;
        retire_valid_i = 1'b0;
        check("R10 flush idx", int'(flush_idx_o), 2);
        check("R10 count", int'(count_o), 2);
        check("R10 tail", int'(tail_pos_o), 2);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog (all requirements): actual=running expected=finished");
        finish_run();
    end

    initial begin
        t_reset();
        t_fill();
        t_retire();
        t_basic();
        t_no_match();
        t_oldest();
        t_wrap();
        t_collide();
        finish_run();
    end
endmodule